// File: doc/BRIEF.md
# MDIO Management Frame Engine

This block lets a host reach the management registers of an Ethernet PHY through one 32-bit command/status word. The host writes a command that names a PHY address, a register address and, for writes, 16 data bits. One of two request bits in the same word selects a register read or a register write. The engine then produces the whole serial management frame on MDC and MDIO. The host learns that the frame is finished by polling the same word. For a read, a completion flag goes high and the low half of the word holds the captured value.

The bit clock is derived from the system clock. A parameter sets its half period in system clocks. MDIO is brought out as a data output, a separate output enable for a tristate pad, and an input. The line is assumed to have a pull-up, so a read from an address where no PHY answers returns all ones. Each frame starts with a preamble of 35 ones, which is longer than the minimum of 32.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: After reset the command/status word reads zero, MDC is low and the MDIO output enable is low.
- R2: A write frame is 67 bit times with MDIO driven throughout: 35 ones, start 0,1, opcode 0,1, PHY address (word bits 25:21) MSB first, register address (bits 20:16) MSB first, turnaround 1,0, then data (bits 15:0) MSB first.
- R3: A read frame drives 35 ones, start 0,1, opcode 1,0 and the two addresses MSB first (49 bits). It then releases MDIO for 17 bit times. The first of these is discarded and the remaining 16 are sampled MSB first while MDC is high.
- R4: At the end of a read, bit 28 is set and bits 15:0 hold the sampled value. When no PHY drives the line, that value is 16'hFFFF.
- R5: Bit 27 requests a read and bit 26 requests a write. The accepted request bit reads back as 1 while the frame runs and clears when it ends. If both are written as 1, the frame is a read and bit 26 reads back 0.
- R6: A command written while a frame is running is ignored: the frame, the stored addresses and the result are those of the earlier command.
- R7: An accepted command clears bit 28 in the following cycle. A command with neither request bit set updates the stored fields and starts no frame.
- R8: Each bit time is 2*MDC_HALF system clocks, with MDC low for the first half and high for the second. The request bit clears exactly 2*N*MDC_HALF clocks after the accepting edge, where N is the bit count of the frame. MDC stays low while idle.
- R9: At the end of a write, bit 28 stays 0 and bits 15:0 still hold the written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_we_i | input | 1 | Write strobe for the command word |
| cmd_wdata_i | input | 32 | Command word written by the host |
| cmd_rdata_o | output | 32 | Command/status word read by the host |
| mdc_o | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output data |
| mdio_oe_o | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
Writes are tried at every PHY address, each paired with a different register address and a data word that changes per address. Reads are swept over every PHY address and over every register address at a fixed PHY. Because the data and addresses vary bit by bit, an error in bit order, field placement or opcode shows up as a frame mismatch rather than hiding behind a symmetric pattern. The PHY model answers reads with an arithmetic function of both addresses and stays silent at address 31. This separates sampled data from the pulled-up all-ones result. Further runs cover commands issued mid-frame, a word with both request bits set, and a word with neither, which separates the read/write priority from the rule that ignores commands while busy.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PRE_LEN = 35;
  localparam int AW      = 5;
  localparam int DW      = 16;
  localparam int WR_BITS = PRE_LEN + 2 + 2 + AW + AW + 2 + DW;
  localparam int RD_DRV  = PRE_LEN + 2 + 2 + AW + AW;
  localparam int RD_BITS = RD_DRV + 1 + DW;
  localparam int IDX_W   = $clog2(WR_BITS);

  localparam int B_DONE  = 28;
  localparam int B_RD    = 27;
  localparam int B_WR    = 26;
  localparam int B_PHY   = 21;
  localparam int B_REG   = 16;

  typedef enum logic {OP_READ = 1'b0, OP_WRITE = 1'b1} mdio_op_e;
endpackage

// File: rtl/mdio_half_tick.sv
module mdio_half_tick #(
  parameter int HALF = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q;
  logic          at_end;

  assign at_end = (cnt_q == CW'(HALF - 1));
  assign tick_o = en_i & at_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!en_i || at_end) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  generate
    if (HALF > 1) begin : g_gap_chk
      a_r8_tick_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          start_i,
  input  mdio_op_e      op_i,
  input  logic [AW-1:0] phy_i,
  input  logic [AW-1:0] reg_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          mdio_i,
  output logic          busy_o,
  output logic          mdc_o,
  output logic          mdio_o,
  output logic          mdio_oe_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o
);
  logic               busy_q, high_q;
  mdio_op_e           op_q;
  logic [IDX_W-1:0]   idx_q, last_idx;
  logic [WR_BITS-1:0] frame_q;
  logic [DW-1:0]      rx_q;
  logic               drive, bit_end;

  assign last_idx = (op_q == OP_WRITE) ? IDX_W'(WR_BITS - 1) : IDX_W'(RD_BITS - 1);
  assign bit_end  = busy_q & tick_i & high_q;
  assign drive    = busy_q & ((op_q == OP_WRITE) | (idx_q < IDX_W'(RD_DRV)));

  assign busy_o    = busy_q;
  assign mdc_o     = busy_q & high_q;
  assign mdio_oe_o = drive;
  assign mdio_o    = drive ? frame_q[WR_BITS-1] : 1'b1;
  assign done_o    = bit_end & (idx_q == last_idx);
  assign rdata_o   = {rx_q[DW-2:0], mdio_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      high_q  <= 1'b0;
      op_q    <= OP_WRITE;
      idx_q   <= '0;
      frame_q <= '0;
      rx_q    <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      high_q <= 1'b0;
      idx_q  <= '0;
      op_q   <= op_i;
      if (op_i == OP_WRITE)
        frame_q <= {{PRE_LEN{1'b1}}, 2'b01, 2'b01, phy_i, reg_i, 2'b10, wdata_i};
      else
        frame_q <= {{PRE_LEN{1'b1}}, 2'b01, 2'b10, phy_i, reg_i, {(WR_BITS-RD_DRV){1'b0}}};
    end else if (busy_q && tick_i) begin
      if (!high_q) begin
        high_q <= 1'b1;
      end else begin
        high_q  <= 1'b0;
        frame_q <= {frame_q[WR_BITS-2:0], 1'b0};
        // first released bit is turnaround, dropped
        if (op_q == OP_READ && idx_q > IDX_W'(RD_DRV))
          rx_q <= {rx_q[DW-2:0], mdio_i};
        if (idx_q == last_idx) busy_q <= 1'b0;
        else                   idx_q  <= idx_q + 1'b1;
      end
    end
  end

  a_r3_mdio_stable_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdc_o && $past(mdc_o)) |-> ($stable(mdio_o) && $stable(mdio_oe_o)));

  a_r8_rise_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mdc_o) |-> $past(tick_i));

  a_r4_done_ends_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
endmodule

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl
  import mdio_pkg::*;
#(
  parameter int MDC_HALF = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_we_i,
  input  logic [31:0] cmd_wdata_i,
  output logic [31:0] cmd_rdata_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  logic [AW-1:0] phy_q, reg_q;
  logic [DW-1:0] data_q, eng_rdata;
  logic          done_q, rd_req_q, wr_req_q;
  logic          eng_busy, eng_done, tick, accept, start;
  mdio_op_e      start_op;

  assign accept   = cmd_we_i & ~eng_busy;
  assign start    = accept & (cmd_wdata_i[B_RD] | cmd_wdata_i[B_WR]);
  assign start_op = cmd_wdata_i[B_RD] ? OP_READ : OP_WRITE;

  assign cmd_rdata_o = {3'b000, done_q, rd_req_q, wr_req_q, phy_q, reg_q, data_q};

  mdio_half_tick #(.HALF(MDC_HALF)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (eng_busy),
    .tick_o (tick)
  );

  mdio_frame_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .start_i   (start),
    .op_i      (start_op),
    .phy_i     (cmd_wdata_i[B_PHY +: AW]),
    .reg_i     (cmd_wdata_i[B_REG +: AW]),
    .wdata_i   (cmd_wdata_i[DW-1:0]),
    .mdio_i    (mdio_i),
    .busy_o    (eng_busy),
    .mdc_o     (mdc_o),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o),
    .done_o    (eng_done),
    .rdata_o   (eng_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phy_q    <= '0;
      reg_q    <= '0;
      data_q   <= '0;
      done_q   <= 1'b0;
      rd_req_q <= 1'b0;
      wr_req_q <= 1'b0;
    end else if (accept) begin
      phy_q    <= cmd_wdata_i[B_PHY +: AW];
      reg_q    <= cmd_wdata_i[B_REG +: AW];
      data_q   <= cmd_wdata_i[DW-1:0];
      done_q   <= 1'b0;
      rd_req_q <= cmd_wdata_i[B_RD];
      wr_req_q <= cmd_wdata_i[B_WR] & ~cmd_wdata_i[B_RD];
    end else if (eng_done) begin
      rd_req_q <= 1'b0;
      wr_req_q <= 1'b0;
      if (rd_req_q) begin
        done_q <= 1'b1;
        data_q <= eng_rdata;
      end
    end
  end

  a_r5_req_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rd_req_q, wr_req_q}));

  a_r5_req_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_busy |-> (rd_req_q || wr_req_q));

  a_r6_fields_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_busy && $past(eng_busy)) |-> ($stable(phy_q) && $stable(reg_q)));

  a_r7_done_clear_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(eng_busy) |-> !done_q);
endmodule

// File: tb/mdio_cmd_ctrl_test.sv
module mdio_cmd_ctrl_test;
  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_we = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic [31:0] cmd_rdata;
  logic        mdc, mdio_out, mdio_oe;
  logic        mdio_in = 1'b1;

  int n_cmp = 0;
  int n_bad = 0;

  logic        mon_clr = 1'b1;
  logic        resp_en = 1'b0;
  logic [15:0] resp_val = '0;
  logic        mdc_prev = 1'b0;
  int          rises = 0;
  logic [66:0] cap = '0;
  logic [66:0] oeh = '0;

  always #4 clk = ~clk;

  mdio_cmd_ctrl #(.MDC_HALF(HALF)) uut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .cmd_we_i    (cmd_we),
    .cmd_wdata_i (cmd_wdata),
    .cmd_rdata_o (cmd_rdata),
    .mdc_o       (mdc),
    .mdio_o      (mdio_out),
    .mdio_oe_o   (mdio_oe),
    .mdio_i      (mdio_in)
  );

  // PHY model: records driven bits on MDC rise, answers reads
  always_ff @(posedge clk) begin
    mdc_prev <= mdc;
    if (mon_clr) begin
      rises   <= 0;
      cap     <= '0;
      oeh     <= '0;
      mdio_in <= 1'b1;
    end else if (mdc && !mdc_prev) begin
      rises <= rises + 1;
      cap   <= {cap[65:0], mdio_out};
      oeh   <= {oeh[65:0], mdio_oe};
      if (resp_en && rises >= 50 && rises <= 65) mdio_in <= resp_val[65 - rises];
      else                                       mdio_in <= 1'b1;
    end
  end

  function automatic logic [15:0] resp_of(input logic [4:0] p, input logic [4:0] r);
    resp_of = ({11'b0, p} * 16'h0421) ^ ({11'b0, r} * 16'h1357) ^ 16'h5A5A;
  endfunction

  task automatic check(input logic ok, input string req, input logic [66:0] act,
                       input logic [66:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] w);
    cmd_we    = 1'b1;
    cmd_wdata = w;
    @(posedge clk);
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic do_cmd(input logic rd, input logic wr, input logic [4:0] p,
                        input logic [4:0] r, input logic [15:0] d, input logic intrude);
    int          n;
    logic [15:0] er;
    logic        present;
    logic [66:0] wf;
    logic [48:0] rf;
    n       = rd ? 66 : 67;
    present = (p != 5'd31);
    er      = present ? resp_of(p, r) : 16'hFFFF;
    @(negedge clk);
    mon_clr  = 1'b1;
    resp_val = resp_of(p, r);
    resp_en  = rd & present;
    @(negedge clk);
    mon_clr = 1'b0;
    issue({4'b0, rd, wr, p, r, d});
    check(cmd_rdata[27] == rd && cmd_rdata[26] == !rd, "R5 req readback", 67'(cmd_rdata[27:26]), 67'({rd, !rd}));
    check(cmd_rdata[28] == 1'b0, "R7 done cleared", 67'(cmd_rdata[28]), 67'(0));
    check(mdc == 1'b0, "R8 mdc low first half", 67'(mdc), 67'(0));
    repeat (HALF) @(negedge clk);
    check(mdc == 1'b1, "R8 mdc high second half", 67'(mdc), 67'(1));
    if (intrude) begin
      issue({4'b0, 1'b0, 1'b1, ~p, ~r, ~d});
      repeat (2*n*HALF - 2 - HALF) @(negedge clk);
    end else begin
      repeat (2*n*HALF - 1 - HALF) @(negedge clk);
    end
    check(cmd_rdata[27:26] != 2'b00 && mdc, "R8 busy until last half", 67'({cmd_rdata[27:26], mdc}), 67'({rd, !rd, 1'b1}));
    @(negedge clk);
    check(cmd_rdata[27:26] == 2'b00 && !mdc, "R8 frame end time", 67'({cmd_rdata[27:26], mdc}), 67'(0));
    check(cmd_rdata[25:21] == p && cmd_rdata[20:16] == r,
          intrude ? "R6 fields kept" : "R5 fields stored", 67'(cmd_rdata[25:16]), 67'({p, r}));
    check(rises == n, "R8 bit count", 67'(rises), 67'(n));
    if (rd) begin
      rf = {{35{1'b1}}, 2'b01, 2'b10, p, r};
      check(cmd_rdata[28] == 1'b1, "R4 done set", 67'(cmd_rdata[28]), 67'(1));
      check(cmd_rdata[15:0] == er, "R4 read data", 67'(cmd_rdata[15:0]), 67'(er));
      check(cap[65:17] == rf, "R3 read header", 67'(cap[65:17]), 67'(rf));
      check(oeh[65:0] == {{49{1'b1}}, 17'b0}, "R3 release", 67'(oeh[65:0]), 67'({{49{1'b1}}, 17'b0}));
    end else begin
      wf = {{35{1'b1}}, 2'b01, 2'b01, p, r, 2'b10, d};
      check(cmd_rdata[28] == 1'b0, "R9 done stays clear", 67'(cmd_rdata[28]), 67'(0));
      check(cmd_rdata[15:0] == d, "R9 data kept", 67'(cmd_rdata[15:0]), 67'(d));
      check(cap == wf, intrude ? "R6 frame unchanged" : "R2 write frame", cap, wf);
      check(oeh == {67{1'b1}}, "R2 driven", oeh, {67{1'b1}});
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(cmd_rdata == 32'h0 && !mdc && !mdio_oe, "R1 reset state",
          67'({cmd_rdata, mdc, mdio_oe}), 67'(0));
    rst_ni = 1'b1;
    @(negedge clk);
    for (int p = 0; p < 32; p++) begin
      do_cmd(1'b0, 1'b1, 5'(p), 5'(p) ^ 5'd5, 16'(p * 16'h0813) ^ 16'hC3A5, 1'b0);
      do_cmd(1'b1, 1'b0, 5'(p), ~5'(p), 16'h0000, 1'b0);
    end
    for (int r = 0; r < 32; r++)
      do_cmd(1'b1, 1'b0, 5'd3, 5'(r), 16'h1111, 1'b0);
    do_cmd(1'b1, 1'b1, 5'd12, 5'd22, 16'hBEEF, 1'b0);
    do_cmd(1'b0, 1'b1, 5'd9, 5'd17, 16'h6A3C, 1'b1);
    do_cmd(1'b1, 1'b0, 5'd21, 5'd4, 16'h0000, 1'b1);
    // R7: word with no request bit
    @(negedge clk);
    mon_clr = 1'b1;
    @(negedge clk);
    mon_clr = 1'b0;
    issue({4'b0, 1'b0, 1'b0, 5'd7, 5'd9, 16'h1234});
    check(cmd_rdata == {4'b0, 2'b00, 5'd7, 5'd9, 16'h1234}, "R7 no-request word",
          67'(cmd_rdata), 67'({4'b0, 2'b00, 5'd7, 5'd9, 16'h1234}));
    repeat (40) @(negedge clk);
    check(rises == 0 && !mdc && !mdio_oe, "R7 no frame started", 67'(rises), 67'(0));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R8 actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule